// File: doc/BRIEF.md
# Lookup-Table Pattern and Edge Trigger

This block decides, one sample at a time, whether a 16-channel logic capture should trigger. The channels are split into four groups of four. The four bits of each group address a 16-bit lookup entry. When all four group lookups of a table return 1, that table reports a match. There are three such tables. The first holds a value/mask pattern that may constrain any number of channels. The other two each watch a single channel, and their match history turns into rise and fall conditions. A 16-entry Boolean function table combines those four conditions. The combined result is then qualified by the pattern match. With edges disabled, the pattern match triggers on its own.

A separate fast mode ignores all the tables. It fires on a rising or falling edge of one pin, chosen from the lowest eight channels. Software loads the tables through a byte command port. One command enters programming mode. Each row command then writes one lookup index across all tables at once. Any other command leaves programming mode. A start pulse re-arms the block. The first qualifying sample sets a sticky fired flag and latches that sample's position.

Top module: `trig_unit`

## Requirements
- R1: After reset `fired` is 0 and `firePos` is 0. A `start` pulse clears `fired`, `firePos`, the sample position counter and all edge history. A sample presented in the same cycle as `start` is ignored.
- R2: A table matches when, for every group g (channels 4g..4g+1+2+... i.e. bits 4g+3..4g), bit `sample[4g+3:4g]` of that table's group-g entry is 1. A row write with index j loads bit j of every entry: `cmdData[g]` into the pattern table group g, `cmdData[4+g]` into edge table 0 group g, `cmdData[8+g]` into edge table 1 group g, and `cmdData[12]` into function-table bit j.
- R3: Command byte 0x20 enters programming mode. Byte 0x30+j (j = 0..15) writes row j only while in programming mode. Any other byte leaves programming mode. A row command given outside programming mode changes no table.
- R4: For each edge table, the rise condition is previous match 0 and current match 1, and the fall condition is previous match 1 and current match 0. The previous match starts at 0 after `start`.
- R5: With `edgeEnable` = 1 and `fastMode` = 0, a sample triggers when the pattern table matches and bit {fall1, rise1, fall0, rise0} of the function table is 1, where that index is 4 bits with rise0 as the LSB.
- R6: With `edgeEnable` = 0 and `fastMode` = 0, a sample triggers when the pattern table matches.
- R7: With `fastMode` = 1, a sample triggers on an edge of `sample[fastPin]` against the previous valid sample's value of that pin. `fastFall` = 1 selects falling and 0 selects rising. The tables have no effect in this mode.
- R8: The first triggering sample after `start` sets `fired`, which holds until the next `start`. `firePos` takes the 0-based count of valid samples since `start` up to that sample. Later triggers do not change it.
- R9: Cycles with `sampleValid` low neither advance the position count nor update edge history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Re-arm pulse |
| cmdValid | input | 1 | Command byte strobe |
| cmdByte | input | 8 | Command code |
| cmdData | input | 13 | Row bits used by a row-write command |
| edgeEnable | input | 1 | Combine edge conditions through the function table |
| fastMode | input | 1 | Single-pin edge trigger mode |
| fastPin | input | 3 | Pin watched in fast mode |
| fastFall | input | 1 | Fast mode edge polarity, 1 = falling |
| sampleValid | input | 1 | A sample is present this cycle |
| sample | input | 16 | Channel sample word |
| fired | output | 1 | Sticky trigger flag |
| firePos | output | 16 | Position of the triggering sample |

## Verification
A pattern on channels 0-7 is driven with words that differ from it in a single low bit, in the upper nibble of a group, and in unconstrained channels. This shows that every group must agree and that unmasked channels do not matter. Edge scenarios place the watched channel in different groups and set it before and after `start`. They also pair a rise with a failing pattern, and feed an opposite-polarity edge into a function that ORs other conditions. These separate rise from fall, edge table 0 from table 1, and qualification from combination. Fast-mode runs use a pattern that can never match, insert gaps with `sampleValid` low, and send row commands outside programming mode. These show the tables being bypassed, the counter and history being frozen, and the command gating at work.

// File: rtl/trig_pkg.sv
package trig_pkg;
  // Lookup index width; fixed by the row command format (low nibble).
  localparam int GRP_W = 4;

  typedef struct packed {
    logic             rowWrite;
    logic [GRP_W-1:0] rowIdx;
    logic             clearHist;
    logic             sampleEn;
  } trigStrobes_t;

  typedef enum logic {
    CMD_IDLE = 1'b0,
    CMD_PROG = 1'b1
  } cmdState_t;
endpackage

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int CH_W       = 16,
  parameter int FAST_SEL_W = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  trigStrobes_t                strb,
  input  logic [3*(CH_W/GRP_W)+0:0]   rowData,
  input  logic                        edgeEnable,
  input  logic                        fastMode,
  input  logic [FAST_SEL_W-1:0]       fastPin,
  input  logic                        fastFall,
  input  logic [CH_W-1:0]             sample,
  output logic                        condHit
);
  localparam int NGRP   = CH_W / GRP_W;
  localparam int ENT    = 1 << GRP_W;
  localparam int FAST_N = 1 << FAST_SEL_W;

  logic [NGRP-1:0][ENT-1:0] vmTab, e0Tab, e1Tab;
  logic [ENT-1:0]           funcTab;
  logic [NGRP-1:0]          vmHit, e0Hit, e1Hit;
  logic                     prevM0, prevM1;
  logic [FAST_N-1:0]        prevFast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vmTab   <= '0;
      e0Tab   <= '0;
      e1Tab   <= '0;
      funcTab <= '0;
    end else if (strb.rowWrite) begin
      for (int g = 0; g < NGRP; g++) begin
        vmTab[g][strb.rowIdx] <= rowData[g];
        e0Tab[g][strb.rowIdx] <= rowData[NGRP+g];
        e1Tab[g][strb.rowIdx] <= rowData[2*NGRP+g];
      end
      funcTab[strb.rowIdx] <= rowData[3*NGRP];
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : gLookup
    logic [GRP_W-1:0] grpIdx;
    assign grpIdx   = sample[g*GRP_W +: GRP_W];
    assign vmHit[g] = vmTab[g][grpIdx];
    assign e0Hit[g] = e0Tab[g][grpIdx];
    assign e1Hit[g] = e1Tab[g][grpIdx];
  end

  logic vmMatch, m0, m1, rise0, fall0, rise1, fall1;
  logic [3:0] funcIdx;
  logic fastCur, fastPrev, fastEdge;

  assign vmMatch  = &vmHit;
  assign m0       = &e0Hit;
  assign m1       = &e1Hit;
  assign rise0    = m0 & ~prevM0;
  assign fall0    = ~m0 & prevM0;
  assign rise1    = m1 & ~prevM1;
  assign fall1    = ~m1 & prevM1;
  assign funcIdx  = {fall1, rise1, fall0, rise0};
  assign fastCur  = sample[fastPin];
  assign fastPrev = prevFast[fastPin];
  assign fastEdge = fastFall ? (fastPrev & ~fastCur) : (~fastPrev & fastCur);

  always_comb begin
    if (fastMode)        condHit = fastEdge;
    else if (edgeEnable) condHit = vmMatch & funcTab[funcIdx];
    else                 condHit = vmMatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevM0   <= 1'b0;
      prevM1   <= 1'b0;
      prevFast <= '0;
    end else if (strb.clearHist) begin
      prevM0   <= 1'b0;
      prevM1   <= 1'b0;
      prevFast <= '0;
    end else if (strb.sampleEn) begin
      prevM0   <= m0;
      prevM1   <= m1;
      prevFast <= sample[FAST_N-1:0];
    end
  end

  // R4: history is empty right after a re-arm
  a_r4_hist_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearHist |=> (!prevM0 && !prevM1 && prevFast == '0));
  // R9: history frozen when no sample is taken
  a_r9_hist_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.sampleEn && !strb.clearHist) |=> ($stable(prevM0) && $stable(prevM1) && $stable(prevFast)));
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cmdValid,
  input  logic [7:0]       cmdByte,
  input  logic             sampleValid,
  input  logic             condHit,
  output trigStrobes_t     strb,
  output logic             fired,
  output logic [POS_W-1:0] firePos
);
  localparam logic [7:0]       CMD_ENTER = 8'h20;
  localparam logic [7-GRP_W:0] ROW_OP    = 4'h3;

  cmdState_t         state;
  logic [POS_W-1:0]  posCnt;
  logic              isRowCmd;

  assign isRowCmd       = cmdByte[7:GRP_W] == ROW_OP;
  assign strb.rowWrite  = cmdValid && state == CMD_PROG && isRowCmd;
  assign strb.rowIdx    = cmdByte[GRP_W-1:0];
  assign strb.clearHist = start;
  assign strb.sampleEn  = sampleValid && !start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= CMD_IDLE;
    end else if (cmdValid) begin
      if (cmdByte == CMD_ENTER)                 state <= CMD_PROG;
      else if (!(state == CMD_PROG && isRowCmd)) state <= CMD_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posCnt  <= '0;
      fired   <= 1'b0;
      firePos <= '0;
    end else if (start) begin
      posCnt  <= '0;
      fired   <= 1'b0;
      firePos <= '0;
    end else if (strb.sampleEn) begin
      posCnt <= posCnt + 1'b1;
      if (!fired && condHit) begin
        fired   <= 1'b1;
        firePos <= posCnt;
      end
    end
  end

  // R8: sticky flag and frozen position
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (fired && !start) |=> fired);
  a_r8_pos_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fired && !start) |=> $stable(firePos));
  a_r8_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fired) |-> $past(sampleValid && condHit));
  // R1: re-arm clears result
  a_r1_rearm: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!fired && firePos == '0));
  // R3: enter command always lands in programming mode
  a_r3_enter: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdByte == CMD_ENTER) |=> state == CMD_PROG);
endmodule

// File: rtl/trig_unit.sv
module trig_unit
  import trig_pkg::*;
#(
  parameter int CH_W       = 16,
  parameter int FAST_SEL_W = 3,
  parameter int POS_W      = 16,
  localparam int ROW_W     = 3*(CH_W/GRP_W)+1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  cmdValid,
  input  logic [7:0]            cmdByte,
  input  logic [ROW_W-1:0]      cmdData,
  input  logic                  edgeEnable,
  input  logic                  fastMode,
  input  logic [FAST_SEL_W-1:0] fastPin,
  input  logic                  fastFall,
  input  logic                  sampleValid,
  input  logic [CH_W-1:0]       sample,
  output logic                  fired,
  output logic [POS_W-1:0]      firePos
);
  trigStrobes_t strb;
  logic         condHit;

  trig_ctrl #(.POS_W(POS_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .cmdValid(cmdValid),
    .cmdByte(cmdByte), .sampleValid(sampleValid), .condHit(condHit),
    .strb(strb), .fired(fired), .firePos(firePos)
  );

  trig_datapath #(.CH_W(CH_W), .FAST_SEL_W(FAST_SEL_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .rowData(cmdData),
    .edgeEnable(edgeEnable), .fastMode(fastMode), .fastPin(fastPin),
    .fastFall(fastFall), .sample(sample), .condHit(condHit)
  );
endmodule

// File: tb/trig_unit_test.sv
`timescale 1ns/1ps
module trig_unit_test;
  logic clk = 0, rstN = 0, start = 0, cmdValid = 0;
  logic [7:0] cmdByte = '0;
  logic [12:0] cmdData = '0;
  logic edgeEnable = 0, fastMode = 0, fastFall = 0, sampleValid = 0;
  logic [2:0] fastPin = '0;
  logic [15:0] sample = '0;
  logic fired;
  logic [15:0] firePos;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trig_unit uut (.*);

  typedef struct packed { logic [15:0] smp; logic expF; logic [15:0] expP; } vec_t;
  localparam vec_t VECS [6] = '{
    '{16'h1234, 1'b0, 16'd0}, '{16'hFF5A, 1'b0, 16'd0}, '{16'h33A4, 1'b0, 16'd0},
    '{16'h77A5, 1'b1, 16'd3}, '{16'h00A5, 1'b1, 16'd3}, '{16'h0000, 1'b1, 16'd3}};

  function automatic logic [15:0] lutBits(logic [15:0] v, logic [15:0] m, int g);
    logic [15:0] r;
    for (int j = 0; j < 16; j++) begin
      r[j] = 1'b1;
      for (int k = 0; k < 4; k++)
        if (m[g*4+k] && (j[k] != v[g*4+k])) r[j] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [15:0] funcOf(logic [3:0] sel);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = |(i[3:0] & sel);
    return r;
  endfunction

  task automatic cmd(logic [7:0] b, logic [12:0] d);
    cmdValid = 1; cmdByte = b; cmdData = d;
    @(negedge clk);
    cmdValid = 0;
  endtask

  // pattern v/m, edge channels c0/c1, function selector {fall1,rise1,fall0,rise0}
  task automatic progAll(logic [15:0] v, logic [15:0] m, int c0, int c1, logic [3:0] sel);
    logic [15:0] ch0, ch1, fn;
    ch0 = 16'(1) << c0; ch1 = 16'(1) << c1; fn = funcOf(sel);
    cmd(8'h20, '0);
    for (int j = 0; j < 16; j++) begin
      logic [12:0] d;
      for (int g = 0; g < 4; g++) begin
        d[g]   = lutBits(v, m, g)[j];
        d[4+g] = lutBits(ch0, ch0, g)[j];
        d[8+g] = lutBits(ch1, ch1, g)[j];
      end
      d[12] = fn[j];
      cmd(8'h30 | 8'(j), d);
    end
    cmd(8'h01, '0);
  endtask

  task automatic rearm();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic feed(logic [15:0] s);
    sampleValid = 1; sample = s; @(negedge clk); sampleValid = 0;
  endtask

  task automatic chk(string tag, logic expF, logic [15:0] expP);
    total++;
    if (fired !== expF || firePos !== expP) begin
      bad++;
      $display("FAIL %s: fired=%0b firePos=%0d expected fired=%0b firePos=%0d",
               tag, fired, firePos, expF, expP);
    end
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset", 0, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 after reset release", 0, 0);

    // R2 R6: pattern only, channels 0-7 = 0xA5
    progAll(16'h00A5, 16'h00FF, 0, 1, 4'h0);
    edgeEnable = 0;
    rearm();
    foreach (VECS[i]) begin
      feed(VECS[i].smp);
      chk($sformatf("R2 R6 R8 vector %0d", i), VECS[i].expF, VECS[i].expP);
    end
    rearm();
    chk("R1 start clears", 0, 0);
    start = 1; sampleValid = 1; sample = 16'h00A5; @(negedge clk);
    start = 0; sampleValid = 0;
    chk("R1 sample with start ignored", 0, 0);

    // R4 R5: rise on channel 5 via edge table 0
    progAll(16'h0000, 16'h0000, 5, 9, 4'b0001);
    edgeEnable = 1;
    rearm();
    feed(16'h0000); feed(16'h0000);
    chk("R4 no rise yet", 0, 0);
    feed(16'h0020);
    chk("R4 rise ch5", 1, 2);
    rearm();
    feed(16'h0020);
    chk("R4 history cleared by start", 1, 0);

    // R4 R5: fall on channel 9 via edge table 1
    progAll(16'h0000, 16'h0000, 5, 9, 4'b1000);
    rearm();
    feed(16'h0200); feed(16'h0200);
    chk("R4 rise on fall-only function", 0, 0);
    feed(16'h0000);
    chk("R4 R5 fall ch9", 1, 2);

    // R5: pattern qualifies the edge
    progAll(16'h0001, 16'h0001, 5, 9, 4'b0001);
    rearm();
    feed(16'h0020);
    chk("R5 rise without pattern", 0, 0);
    feed(16'h0000); feed(16'h0021);
    chk("R5 rise with pattern", 1, 2);

    // R5: OR of rise0 and fall1
    progAll(16'h0000, 16'h0000, 5, 9, 4'b1001);
    rearm();
    feed(16'h0200); feed(16'h0200);
    chk("R5 rise1 not selected", 0, 0);
    feed(16'h0000);
    chk("R5 fall1 selected", 1, 2);
    rearm();
    feed(16'h0020);
    chk("R5 rise0 selected", 1, 0);

    // R7: fast mode, pattern made unmatchable
    progAll(16'hFFFF, 16'hFFFF, 5, 9, 4'b1111);
    fastMode = 1; fastPin = 3'd3; fastFall = 1;
    rearm();
    feed(16'h0008);
    chk("R7 rise ignored when falling", 0, 0);
    feed(16'h0000);
    chk("R7 fall pin3", 1, 1);

    // R7 R9: rising pin 6 with invalid gaps
    fastPin = 3'd6; fastFall = 0;
    rearm();
    feed(16'h0000);
    sample = 16'h0040; repeat (3) @(negedge clk);
    sample = 16'h0000; @(negedge clk);
    chk("R9 gaps do nothing", 0, 0);
    feed(16'h0040);
    chk("R7 R9 rise pin6 position", 1, 1);

    // R3: row commands outside programming mode ignored
    fastMode = 0; edgeEnable = 0;
    progAll(16'h0000, 16'h0000, 0, 1, 4'h0);
    cmd(8'h30, 13'h0000);
    cmd(8'h35, 13'h0000);
    rearm();
    feed(16'h0000);
    chk("R3 row 0 untouched outside prog mode", 1, 0);
    rearm();
    feed(16'h5555);
    chk("R3 row 5 untouched outside prog mode", 1, 0);
    // R3: inside programming mode the write lands
    cmd(8'h20, '0); cmd(8'h30, 13'h0000); cmd(8'h01, '0);
    rearm();
    feed(16'h0000);
    chk("R3 row 0 written in prog mode", 0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule